// File: doc/BRIEF.md
# Encoded Request-Level Chain Decoder

This block takes a four-bit encoded interrupt-request level from external pins and turns it into assertion and enable control for a chain of level-sensitive interrupt sources. A level of zero means that no request is present. Levels 1 through 15 are requests, with 1 the lowest priority and 15 the highest. The level is inverted (XOR with all ones) to give a chain position. The member at that position is asserted and every other member is released. Chain position 0 is the first member in link order and is the target of level 15.

The outputs go to a pending aggregator that keeps per-source enable counts and assertion state. The aggregator reports back, one bit per source, whether that source's enable count is non-zero. The decoder uses this to give a selected but disabled source one enable increment, so that the source can become pending. For each member it drives a level, one-cycle pulses for assertion and release adjustments, a one-cycle enable-increment pulse, and a sticky flag that records that the increment was issued.

A two-state controller tracks whether any member is selected. The states are QUIET (no member selected) and HOLD (exactly one member selected). The transitions are: ENGAGE (QUIET to HOLD, on a request that maps into the chain), SWITCH (HOLD to HOLD, while a request stays in the chain, whether the level changes or not), RELEASE (HOLD to QUIET, on level 0 or a position beyond the chain) and IDLE (QUIET to QUIET). All outputs are registered, so they reflect the level that was sampled at the most recent clock edge.

Top module: `irl_level_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is 0 and the controller is in QUIET.
- R2: For a sampled level L other than 0, the chain position is L XOR 15. Bit (L XOR 15) of `src_assert` is high in the cycle after the edge that sampled L. Level 15 drives bit 0 and level 1 drives bit 14.
- R3: At most one bit of `src_assert` is high at a time. For each member whose bit falls, `src_fall` pulses high for exactly one cycle.
- R4: Level 0 maps to position 15, which lies beyond the 15-member chain. All `src_assert` bits go low and `req_any` goes low.
- R5: When the selected member has its `en_nonzero` bit at 0 and `src_en_boost` is not yet set, `src_en_inc` pulses for one cycle and `src_en_boost` becomes set. `src_en_boost` stays set until reset, and no further increment is issued for that member.
- R6: `src_rise` pulses only when a member changes from released to asserted. If the same level is held, or sampled again, no further rise pulse is produced.
- R7: `req_any` is high exactly when one member is selected, which is the controller's HOLD state.
- R8: The `en_nonzero` bits of members that are not selected have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irl_level | input | 4 | Encoded request level; 0 means no request, 15 is the highest priority |
| en_nonzero | input | 15 | Per member: the aggregator's enable count is non-zero |
| src_assert | output | 15 | Per member assertion level |
| src_rise | output | 15 | One-cycle pulse: member newly asserted |
| src_fall | output | 15 | One-cycle pulse: member released |
| src_en_inc | output | 15 | One-cycle pulse: add one to the member's enable count |
| src_en_boost | output | 15 | Sticky flag: the enable increment was issued |
| req_any | output | 1 | A chain member is currently selected |

## Verification
The bench sweeps every ordered pair of levels, and holds each target level for an extra cycle. This targets three faults. A design that skipped the XOR would light the mirrored member. One that let level 0 fall through to position 15 would assert a nonexistent member or leave `req_any` high. One that pulsed `src_rise` on a repeated level would make the aggregator count one source twice. The `en_nonzero` pattern changes on every step, so a design that issued a second increment to an already boosted member, or that reacted to the enable status of a member that is not selected, would produce extra `src_en_inc` pulses or set stray boost flags. A second reset at the end checks that the sticky flags clear.

// File: rtl/irl_dec_pkg.sv
package irl_dec_pkg;

    // Controller states: no member selected / one member selected.
    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_HOLD  = 1'b1
    } irl_state_e;

    // Transition names for the controller (used for readability).
    typedef enum logic [1:0] {
        TR_IDLE    = 2'd0,
        TR_ENGAGE  = 2'd1,
        TR_SWITCH  = 2'd2,
        TR_RELEASE = 2'd3
    } irl_trans_e;

endpackage

// File: rtl/irl_level_decode.sv
module irl_level_decode #(
    parameter int LVL_W = 4,
    parameter int N_SRC = 15
) (
    input  logic [LVL_W-1:0] level,
    output logic [N_SRC-1:0] sel,
    output logic             hit
);
    localparam logic [LVL_W-1:0] INV_MASK = {LVL_W{1'b1}};

    logic [LVL_W-1:0] chain_idx;
    logic             has_req;

    // Inversion turns the priority level into a link position.
    assign chain_idx = level ^ INV_MASK;
    assign has_req   = (level != '0);

    for (genvar i = 0; i < N_SRC; i++) begin : g_pos
        assign sel[i] = has_req && (chain_idx == LVL_W'(i));
    end

    assign hit = |sel;

endmodule

// File: rtl/irl_member.sv
module irl_member (
    input  logic clk,
    input  logic rst,
    input  logic sel_nx,
    input  logic en_nz,
    output logic asrt,
    output logic rise,
    output logic fall,
    output logic inc,
    output logic boost
);
    logic asrt_d, rise_d, fall_d, inc_d, boost_d;

    always_comb begin
        asrt_d  = sel_nx;
        rise_d  = sel_nx & ~asrt;
        fall_d  = ~sel_nx & asrt;
        inc_d   = sel_nx & ~en_nz & ~boost;
        boost_d = boost | inc_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asrt  <= 1'b0;
            rise  <= 1'b0;
            fall  <= 1'b0;
            inc   <= 1'b0;
            boost <= 1'b0;
        end else begin
            asrt  <= asrt_d;
            rise  <= rise_d;
            fall  <= fall_d;
            inc   <= inc_d;
            boost <= boost_d;
        end
    end

    // R6: a rise adjustment never lands on a member that was already asserted
    assert_no_double_rise_R6: assert property (@(posedge clk) disable iff (rst)
        rise |-> !$past(asrt));

    // R5: the enable increment is issued at most once until reset
    assert_single_inc_R5: assert property (@(posedge clk) disable iff (rst)
        inc |-> !$past(boost));

    // R5: the boost flag never clears outside reset
    assert_boost_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        $past(boost) |-> boost);

    // R3: a release pulse follows an asserted cycle
    assert_fall_after_assert_R3: assert property (@(posedge clk) disable iff (rst)
        fall |-> ($past(asrt) && !asrt));

endmodule

// File: rtl/irl_level_decoder.sv
module irl_level_decoder #(
    parameter int LVL_W = 4,
    parameter int N_SRC = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] irl_level,
    input  logic [N_SRC-1:0] en_nonzero,
    output logic [N_SRC-1:0] src_assert,
    output logic [N_SRC-1:0] src_rise,
    output logic [N_SRC-1:0] src_fall,
    output logic [N_SRC-1:0] src_en_inc,
    output logic [N_SRC-1:0] src_en_boost,
    output logic             req_any
);
    import irl_dec_pkg::*;

    logic [N_SRC-1:0] sel_nx;
    logic             hit_nx;
    irl_state_e       state_q, state_d;
    irl_trans_e       trans;

    irl_level_decode #(
        .LVL_W (LVL_W),
        .N_SRC (N_SRC)
    ) u_decode (
        .level (irl_level),
        .sel   (sel_nx),
        .hit   (hit_nx)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_member
        irl_member u_member (
            .clk    (clk),
            .rst    (rst),
            .sel_nx (sel_nx[i]),
            .en_nz  (en_nonzero[i]),
            .asrt   (src_assert[i]),
            .rise   (src_rise[i]),
            .fall   (src_fall[i]),
            .inc    (src_en_inc[i]),
            .boost  (src_en_boost[i])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        trans   = TR_IDLE;
        unique case (state_q)
            ST_QUIET: begin
                if (hit_nx) begin
                    state_d = ST_HOLD;
                    trans   = TR_ENGAGE;
                end else begin
                    trans   = TR_IDLE;
                end
            end
            ST_HOLD: begin
                if (hit_nx) begin
                    trans   = TR_SWITCH;
                end else begin
                    state_d = ST_QUIET;
                    trans   = TR_RELEASE;
                end
            end
            default: begin
                state_d = ST_QUIET;
                trans   = TR_RELEASE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_QUIET;
        else     state_q <= state_d;
    end

    // Output process
    always_comb begin
        unique case (state_q)
            ST_QUIET: req_any = 1'b0;
            ST_HOLD:  req_any = 1'b1;
            default:  req_any = 1'b0;
        endcase
    end

    // R3: never more than one member asserted
    assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_assert));

    // R7: the controller state agrees with the member array
    assert_state_match_R7: assert property (@(posedge clk) disable iff (rst)
        req_any == (src_assert != '0));

    // R4: a sampled level of zero releases every member
    assert_zero_level_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(irl_level) == '0) |-> (src_assert == '0));

    // R6: at most one rise pulse per cycle
    assert_rise_count_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(src_rise) <= 1);

endmodule

// File: tb/test_irl_level_decoder.sv
module test_irl_level_decoder;
    localparam int N = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   irl_level = '0;
    logic [N-1:0] en_nonzero = '0;
    logic [N-1:0] src_assert, src_rise, src_fall, src_en_inc, src_en_boost;
    logic         req_any;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_assert = '0, m_rise = '0, m_fall = '0, m_inc = '0, m_boost = '0;
    logic [15:0]  lfsr = 16'hACE1;

    always #10 clk = ~clk;

    irl_level_decoder i_irl_level_decoder (
        .clk          (clk),
        .rst          (rst),
        .irl_level    (irl_level),
        .en_nonzero   (en_nonzero),
        .src_assert   (src_assert),
        .src_rise     (src_rise),
        .src_fall     (src_fall),
        .src_en_inc   (src_en_inc),
        .src_en_boost (src_en_boost),
        .req_any      (req_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string ctx);
        chk({ctx, " R2 assert"},     32'(src_assert),   32'(m_assert));
        chk({ctx, " R6 rise"},       32'(src_rise),     32'(m_rise));
        chk({ctx, " R3 fall"},       32'(src_fall),     32'(m_fall));
        chk({ctx, " R5 inc"},        32'(src_en_inc),   32'(m_inc));
        chk({ctx, " R8 boost"},      32'(src_en_boost), 32'(m_boost));
        chk({ctx, " R7 req_any"},    32'(req_any),      32'(m_assert != '0));
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic apply(input logic [3:0] lvl, input logic [N-1:0] en);
        logic [N-1:0] sel;
        int idx;
        irl_level  = lvl;
        en_nonzero = en;
        @(negedge clk);
        idx = int'(lvl) ^ 15;
        sel = (lvl != 0 && idx < N) ? N'(1) << idx : '0;
        m_rise   = sel & ~m_assert;
        m_fall   = m_assert & ~sel;
        m_inc    = sel & ~en & ~m_boost;
        m_boost  = m_boost | m_inc;
        m_assert = sel;
        compare_all($sformatf("lvl=%0d", lvl));
    endtask

    task automatic reset_check();
        rst = 1'b1;
        irl_level = 4'd9;
        en_nonzero = '0;
        repeat (3) @(negedge clk);
        m_assert = '0; m_rise = '0; m_fall = '0; m_inc = '0; m_boost = '0;
        compare_all("R1 in reset");
        rst = 1'b0;
        irl_level = 4'd0;
        @(negedge clk);
        compare_all("R1 after reset");
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        reset_check();

        // R2 / R4 directed endpoints
        apply(4'd15, '1);
        chk("R2 level 15 -> bit 0", 32'(src_assert), 32'h1);
        apply(4'd1, '1);
        chk("R2 level 1 -> bit 14", 32'(src_assert), 32'h4000);
        apply(4'd0, '1);
        chk("R4 level 0 releases all", 32'({req_any, src_assert}), 32'h0);

        // R5 directed: disabled member gets one increment, then none
        apply(4'd7, '0);
        chk("R5 first inc", 32'(src_en_inc), 32'h100);
        apply(4'd7, '0);
        chk("R5 no second inc", 32'(src_en_inc), 32'h0);
        chk("R6 no repeat rise", 32'(src_rise), 32'h0);

        // Exhaustive ordered pairs with a hold cycle and a scrambled enable pattern
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                apply(4'(a), N'(lfsr));
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                apply(4'(b), N'(lfsr));
                apply(4'(b), ~N'(lfsr));
            end
        end

        // R1: second reset clears the sticky flags
        reset_check();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule